// File: doc/BRIEF.md
# Interrupt Pin Dispatcher with End-of-Interrupt Tracking

This block tracks the request state of a group of interrupt pins and decides when each pin sends a message to the processor side. Each pin has a few configuration inputs: a vector, a destination, a trigger kind (edge or level) and a mask. From these and from the live pin levels, the block offers at most one message at a time on a valid/ready handshake. When several pins are eligible, the lowest-numbered pin goes first.

Edge pins deliver once per rising edge. Holding the pin high does not repeat the message. Level pins carry a remote-pending flag. The flag is set when a message is accepted and cleared by a matching end-of-interrupt broadcast. If the pin is still asserted and unmasked at that point, it is re-sent. A per-pin counter watches for back-to-back end-of-interrupt re-sends. At a limit, the counter holds the pin off until a shared delay timer runs out, which stops an interrupt storm from taking over the output.

Top module: `intr_dispatch`

## Requirements
- R1: A pin's request bit follows its level one cycle late. When the pin is low, no message is offered for it, and an end-of-interrupt finds it not pending.
- R2: An edge pin (trigger bit 0) sends one message per low-to-high transition. While it stays high after acceptance, it sends nothing more.
- R3: A level pin (trigger bit 1) whose remote-pending flag is set is not offered again until a matching end-of-interrupt clears the flag.
- R4: A masked pin (mask bit 1) is never offered. Its request stays recorded, and the message appears on the first clock edge after the mask is cleared.
- R5: An accepted message for a level pin sets that pin's remote-pending flag. An accepted edge message leaves the flag clear.
- R6: An end-of-interrupt with level type 1 clears the remote-pending flag of every level pin whose vector equals the broadcast vector. The flag clears at the sampling edge, and if the pin is pending and unmasked it is offered one edge later. Pins with other vectors are untouched.
- R7: An end-of-interrupt whose level-type bit is 0, or that arrives while the directed mode input is 1, changes no remote-pending flag.
- R8: Each level pin counts back-to-back end-of-interrupt re-sends. The STORM_LIMIT-th such end-of-interrupt zeroes the counter and defers the re-send. An end-of-interrupt that finds the pin masked or not pending zeroes the counter.
- R9: A deferral starts a timer of delay_cycles cycles, or DEF_DELAY cycles when delay_cycles is 0. The held pin is released at the last timer edge and offered on the edge after that. A reset cancels the timer and any holds.
- R10: Among eligible pins the lowest index is offered. A message stays valid and unchanged until ready, and a new message is loaded no earlier than the edge after acceptance.
- R11: After reset, no message is valid and every remote-pending flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | NPINS | Live pin levels |
| cfg_level | input | NPINS | Trigger kind per pin, 1 = level |
| cfg_mask | input | NPINS | Mask per pin, 1 = masked |
| cfg_vector | input | NPINS*VEC_W | Vector per pin, pin i at bits i*VEC_W |
| cfg_dest | input | NPINS*DEST_W | Destination per pin |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_is_level | input | 1 | Broadcast is of level type |
| directed_eoi | input | 1 | Directed mode, broadcasts leave flags alone |
| delay_cycles | input | DELAY_W | Storm delay, 0 selects DEF_DELAY |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_level | output | 1 | Message trigger kind |
| msg_pin | output | $clog2(NPINS) | Source pin index |
| remote_irr | output | NPINS | Remote-pending flags |

## Verification
A pin change driven between edges reaches the request register at the first edge, and the message appears at the second. Remote-pending flags change at the edge that samples the accept or the end-of-interrupt, and a re-send is valid one edge after that. A deferred re-send stays absent for exactly the programmed delay counted from the deferring edge, then appears one edge later. The bench drives inputs on falling edges and advances a counted number of rising edges before each check, so every result is sampled in the exact cycle it becomes due, and also in the cycle before for deferrals and coalescing.

// File: rtl/intr_dispatch_pkg.sv
package intr_dispatch_pkg;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;

  // a broadcast affects remote-pending only when level type and not directed
  function automatic logic eoi_counts(input logic is_level, input logic directed);
    return is_level & ~directed;
  endfunction

  // zero on the programmed delay selects the default
  function automatic int unsigned eff_delay(input int unsigned prog, input int unsigned dflt);
    return (prog == 0) ? dflt : prog;
  endfunction

  // true when this re-send is the one that reaches the storm limit
  function automatic logic storm_reached(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction
endpackage

// File: rtl/intr_pin_state.sv
module intr_pin_state
  import intr_dispatch_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             is_level,
  input  logic             masked,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi_fire,
  input  logic [VEC_W-1:0] eoi_vec,
  input  logic             acc,
  input  logic             acc_lvl,
  input  logic             expire,
  output logic             eligible,
  output logic             rirr,
  output logic             storm
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);

  logic             req_q, done_q, rirr_q, hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic             eoi_hit, pend, redo;

  assign eoi_hit = eoi_fire & (is_level == TRIG_LEVEL) & (vec == eoi_vec);
  assign pend    = req_q & ~masked;
  assign redo    = eoi_hit & pend;
  assign storm   = redo & storm_reached(32'(cnt_q), STORM_LIMIT);

  assign eligible = pend & (is_level ? (~rirr_q & ~hold_q) : ~done_q);
  assign rirr     = rirr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      rirr_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_q <= pin_in;
      if (!pin_in)            done_q <= 1'b0;
      else if (acc && !acc_lvl) done_q <= 1'b1;
      if (acc && acc_lvl)     rirr_q <= 1'b1;
      else if (eoi_hit)       rirr_q <= 1'b0;
      if (storm)              hold_q <= 1'b1;
      else if (expire)        hold_q <= 1'b0;
      if (eoi_hit) begin
        if (!redo || storm)   cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int NPINS = 8,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] req,
  output logic             any,
  output logic [PIN_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = PIN_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_defer_timer.sv
module intr_defer_timer
  import intr_dispatch_pkg::*;
#(
  parameter int DELAY_W   = 16,
  parameter int DEF_DELAY = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DELAY_W-1:0] prog,
  output logic               active,
  output logic               expire
);
  logic [DELAY_W-1:0] cnt_q;

  assign expire = active & (cnt_q == DELAY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start && (!active || expire)) begin
      active <= 1'b1;
      cnt_q  <= DELAY_W'(eff_delay(32'(prog), DEF_DELAY));
    end else if (expire) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (active) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
  import intr_dispatch_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DEF_DELAY   = 1000,
  parameter int DELAY_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPINS-1:0]           pin_level,
  input  logic [NPINS-1:0]           cfg_level,
  input  logic [NPINS-1:0]           cfg_mask,
  input  logic [NPINS*VEC_W-1:0]     cfg_vector,
  input  logic [NPINS*DEST_W-1:0]    cfg_dest,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vector,
  input  logic                       eoi_is_level,
  input  logic                       directed_eoi,
  input  logic [DELAY_W-1:0]         delay_cycles,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [VEC_W-1:0]           msg_vector,
  output logic [DEST_W-1:0]          msg_dest,
  output logic                       msg_level,
  output logic [$clog2(NPINS)-1:0]   msg_pin,
  output logic [NPINS-1:0]           remote_irr
);
  localparam int PIN_W = $clog2(NPINS);

  logic [NPINS-1:0] elig_vec, storm_vec;
  logic             any_elig, load_evt, accept, eoi_fire, storm_any;
  logic             tmr_active, tmr_expire;
  logic [PIN_W-1:0] sel_pin;

  assign eoi_fire  = eoi_valid & eoi_counts(eoi_is_level, directed_eoi);
  assign accept    = msg_valid & msg_ready;
  assign load_evt  = ~msg_valid & any_elig;
  assign storm_any = |storm_vec;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    intr_pin_state #(.VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_level[g]),
      .is_level (cfg_level[g]),
      .masked   (cfg_mask[g]),
      .vec      (cfg_vector[g*VEC_W +: VEC_W]),
      .eoi_fire (eoi_fire),
      .eoi_vec  (eoi_vector),
      .acc      (accept && (msg_pin == PIN_W'(g))),
      .acc_lvl  (msg_level),
      .expire   (tmr_expire),
      .eligible (elig_vec[g]),
      .rirr     (remote_irr[g]),
      .storm    (storm_vec[g])
    );
  end

  intr_prio_pick #(.NPINS(NPINS)) u_pick (
    .req (elig_vec),
    .any (any_elig),
    .idx (sel_pin)
  );

  intr_defer_timer #(.DELAY_W(DELAY_W), .DEF_DELAY(DEF_DELAY)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (storm_any),
    .prog   (delay_cycles),
    .active (tmr_active),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_dest   <= '0;
      msg_level  <= 1'b0;
      msg_pin    <= '0;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end else if (load_evt) begin
      msg_valid  <= 1'b1;
      msg_pin    <= sel_pin;
      msg_vector <= cfg_vector[sel_pin*VEC_W +: VEC_W];
      msg_dest   <= cfg_dest[sel_pin*DEST_W +: DEST_W];
      msg_level  <= cfg_level[sel_pin];
    end
  end
endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPINS-1:0]         cfg_mask,
  input logic [NPINS-1:0]         cfg_level,
  input logic [NPINS-1:0]         remote_irr,
  input logic                     msg_valid,
  input logic                     msg_ready,
  input logic [VEC_W-1:0]         msg_vector,
  input logic [$clog2(NPINS)-1:0] msg_pin,
  input logic                     msg_level,
  input logic                     eoi_valid,
  input logic                     eoi_is_level,
  input logic                     directed_eoi,
  input logic                     load_evt,
  input logic [$clog2(NPINS)-1:0] sel_pin,
  input logic [NPINS-1:0]         elig_vec,
  input logic                     storm_any,
  input logic                     tmr_active
);
  p_rirr_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cfg_level[sel_pin]) |-> !remote_irr[sel_pin]);

  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !cfg_mask[sel_pin]);

  p_accept_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_level) |=> remote_irr[$past(msg_pin)]);

  p_eoi_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && (!eoi_is_level || directed_eoi) && !(msg_valid && msg_ready))
      |=> (remote_irr == $past(remote_irr)));

  p_storm_defers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    storm_any |=> tmr_active);

  p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> ((elig_vec & ~({NPINS{1'b1}} << sel_pin)) == '0));

  p_msg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_pin)));
endmodule

bind intr_dispatch intr_dispatch_chk #(.NPINS(NPINS), .VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mask     (cfg_mask),
  .cfg_level    (cfg_level),
  .remote_irr   (remote_irr),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_vector   (msg_vector),
  .msg_pin      (msg_pin),
  .msg_level    (msg_level),
  .eoi_valid    (eoi_valid),
  .eoi_is_level (eoi_is_level),
  .directed_eoi (directed_eoi),
  .load_evt     (load_evt),
  .sel_pin      (sel_pin),
  .elig_vec     (elig_vec),
  .storm_any    (storm_any),
  .tmr_active   (tmr_active)
);

// File: tb/sim_intr_dispatch.sv
`timescale 1ns/1ps
module sim_intr_dispatch;
  localparam int NP = 4, VW = 8, DW = 4, LIM = 5, DD = 12, DLW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin_level = '0, cfg_level = '0, cfg_mask = '1;
  logic [NP*VW-1:0] cfg_vector = '0;
  logic [NP*DW-1:0] cfg_dest = '0;
  logic eoi_valid = 1'b0, eoi_is_level = 1'b0, directed_eoi = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic [DLW-1:0] delay_cycles = '0;
  logic msg_valid, msg_ready = 1'b0, msg_level;
  logic [VW-1:0] msg_vector;
  logic [DW-1:0] msg_dest;
  logic [1:0] msg_pin;
  logic [NP-1:0] remote_irr;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  intr_dispatch #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW), .STORM_LIMIT(LIM),
                  .DEF_DELAY(DD), .DELAY_W(DLW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .cfg_level(cfg_level),
    .cfg_mask(cfg_mask), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_is_level(eoi_is_level),
    .directed_eoi(directed_eoi), .delay_cycles(delay_cycles), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_level(msg_level), .msg_pin(msg_pin), .remote_irr(remote_irr));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_pin(input int i, input logic [7:0] v, input logic lvl, input logic msk);
    cfg_vector[i*VW +: VW] = v;
    cfg_level[i] = lvl;
    cfg_mask[i]  = msk;
    cfg_dest[i*DW +: DW] = DW'(i + 1);
  endtask

  task automatic expect_msg(input int pin, input logic [7:0] v, input string req);
    chk(64'(msg_valid), 64'd1, req);
    chk(64'(msg_pin), 64'(pin), req);
    chk(64'(msg_vector), 64'(v), req);
    chk(64'(msg_dest), 64'(pin + 1), req);
  endtask

  task automatic take();
    msg_ready = 1'b1;
    step(1);
    msg_ready = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v, input logic lvl, input logic dir);
    eoi_valid = 1'b1; eoi_vector = v; eoi_is_level = lvl; directed_eoi = dir;
    step(1);
    eoi_valid = 1'b0; eoi_is_level = 1'b0; directed_eoi = 1'b0;
  endtask

  task automatic eoi_redeliver(input int n, input int pin, input logic [7:0] v, input string req);
    for (int k = 0; k < n; k++) begin
      eoi(v, 1'b1, 1'b0);
      chk(64'(msg_valid), 64'd0, req);
      step(1);
      expect_msg(pin, v, req);
      take();
    end
  endtask

  task automatic t_reset();
    chk(64'(msg_valid), 64'd0, "R11 no message after reset");
    chk(64'(remote_irr), 64'd0, "R11 flags clear after reset");
  endtask

  task automatic t_edge();
    cfg_pin(0, 8'h30, 1'b0, 1'b0);
    pin_level[0] = 1'b1;
    step(1);
    chk(64'(msg_valid), 64'd0, "R2 not before second edge");
    step(1);
    expect_msg(0, 8'h30, "R2 edge delivery");
    take();
    chk(64'(remote_irr[0]), 64'd0, "R5 edge leaves flag clear");
    step(3);
    chk(64'(msg_valid), 64'd0, "R2 held high coalesced");
    pin_level[0] = 1'b0;
    step(1);
    pin_level[0] = 1'b1;
    step(2);
    expect_msg(0, 8'h30, "R1 new edge re-arms");
    take();
    pin_level[0] = 1'b0;
    step(1);
  endtask

  task automatic t_level();
    cfg_pin(1, 8'h41, 1'b1, 1'b0);
    pin_level[1] = 1'b1;
    step(2);
    expect_msg(1, 8'h41, "R3 level delivery");
    take();
    chk(64'(remote_irr[1]), 64'd1, "R5 level sets flag");
    step(3);
    chk(64'(msg_valid), 64'd0, "R3 blocked while flag set");
    eoi(8'h41, 1'b1, 1'b0);
    chk(64'(remote_irr[1]), 64'd0, "R6 eoi clears flag");
    step(1);
    expect_msg(1, 8'h41, "R6 redelivery");
    take();
    pin_level[1] = 1'b0;
    step(1);
    eoi(8'h41, 1'b1, 1'b0);
    step(2);
    chk(64'(msg_valid), 64'd0, "R1 low pin not redelivered");
    chk(64'(remote_irr[1]), 64'd0, "R6 flag cleared without pending");
  endtask

  task automatic t_ignored();
    pin_level[1] = 1'b1;
    step(2);
    take();
    eoi(8'h41, 1'b0, 1'b0);
    step(1);
    chk(64'(remote_irr[1]), 64'd1, "R7 edge-type eoi ignored");
    chk(64'(msg_valid), 64'd0, "R7 no redelivery edge-type");
    eoi(8'h41, 1'b1, 1'b1);
    step(1);
    chk(64'(remote_irr[1]), 64'd1, "R7 directed mode ignored");
    eoi(8'h42, 1'b1, 1'b0);
    step(1);
    chk(64'(remote_irr[1]), 64'd1, "R6 other vector untouched");
    pin_level[1] = 1'b0;
    step(1);
    eoi(8'h41, 1'b1, 1'b0);
    chk(64'(remote_irr[1]), 64'd0, "R6 matching clears");
  endtask

  task automatic t_mask();
    cfg_pin(2, 8'h52, 1'b1, 1'b1);
    pin_level[2] = 1'b1;
    step(3);
    chk(64'(msg_valid), 64'd0, "R4 masked not delivered");
    cfg_mask[2] = 1'b0;
    step(1);
    expect_msg(2, 8'h52, "R4 recorded request after unmask");
    take();
    pin_level[2] = 1'b0;
    step(1);
    eoi(8'h52, 1'b1, 1'b0);
  endtask

  task automatic t_shared();
    cfg_pin(1, 8'h66, 1'b1, 1'b0);
    cfg_pin(2, 8'h66, 1'b1, 1'b0);
    pin_level[2:1] = 2'b11;
    step(2);
    expect_msg(1, 8'h66, "R10 lowest pin first");
    take();
    chk(64'(msg_valid), 64'd0, "R10 gap after accept");
    step(1);
    expect_msg(2, 8'h66, "R10 next pin");
    take();
    chk(64'(remote_irr[2:1]), 64'd3, "R5 both flags set");
    pin_level[2:1] = 2'b00;
    step(1);
    eoi(8'h66, 1'b1, 1'b0);
    chk(64'(remote_irr[2:1]), 64'd0, "R6 all matching pins cleared");
    step(1);
    chk(64'(msg_valid), 64'd0, "R1 no redelivery low pins");
  endtask

  task automatic t_storm();
    cfg_pin(3, 8'h77, 1'b1, 1'b0);
    delay_cycles = 8'd6;
    pin_level[3] = 1'b1;
    step(2);
    expect_msg(3, 8'h77, "R8 first delivery");
    take();
    eoi_redeliver(LIM - 1, 3, 8'h77, "R8 immediate redelivery");
    eoi(8'h77, 1'b1, 1'b0);
    chk(64'(remote_irr[3]), 64'd0, "R8 limit clears flag");
    step(6);
    chk(64'(msg_valid), 64'd0, "R9 deferred for delay");
    step(1);
    expect_msg(3, 8'h77, "R9 released after delay");
    take();
    eoi_redeliver(3, 3, 8'h77, "R8 partial count");
    pin_level[3] = 1'b0;
    step(1);
    eoi(8'h77, 1'b1, 1'b0);
    step(1);
    chk(64'(msg_valid), 64'd0, "R8 not pending eoi");
    pin_level[3] = 1'b1;
    step(2);
    expect_msg(3, 8'h77, "R1 level re-raised");
    take();
    eoi_redeliver(LIM - 1, 3, 8'h77, "R8 counter cleared by idle eoi");
    delay_cycles = '0;
    eoi(8'h77, 1'b1, 1'b0);
    step(DD);
    chk(64'(msg_valid), 64'd0, "R9 default delay still held");
    step(1);
    expect_msg(3, 8'h77, "R9 default delay release");
    take();
  endtask

  task automatic t_reset_cancel();
    eoi_redeliver(LIM - 1, 3, 8'h77, "R8 count again");
    eoi(8'h77, 1'b1, 1'b0);
    step(2);
    chk(64'(msg_valid), 64'd0, "R8 deferred before reset");
    rst_n = 1'b0;
    step(1);
    t_reset();
    rst_n = 1'b1;
    step(2);
    expect_msg(3, 8'h77, "R9 reset cancels delay");
    take();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_edge();
    t_level();
    t_ignored();
    t_mask();
    t_shared();
    t_storm();
    t_reset_cancel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule